// File: doc/BRIEF.md
# Aligned Divider Change Controller

This block stages new settings for a set of clock-enable dividers and commits them together on an explicit start command. Software writes each divider's settings word (enable flag and ratio) into a staging register, and writes a mask that names the dividers to be realigned. It then drops the start bit and raises it again. The controller holds a busy flag until it finds a cycle in which every masked, enabled divider is at its terminal count. In that one cycle it loads every divider's new settings. It restarts the masked dividers from their new ratio, so that they leave the change in phase with one another.

Each divider is a down-counter that emits a one-cycle tick when it reaches zero, and reloads its ratio on that tick. A ratio value N gives one tick every N+1 cycles. If no common boundary comes within a parameterised number of busy cycles, the commit is forced so that the controller never hangs. A separate mode word selects between bypass and PLL operation. It can also hand that choice to an external enable pin.

Top module: `divsync_ctrl`

## Requirements
- R1: While reset is asserted and after its release, `go_busy` is low, every `div_on` and `div_tick` bit is low, and `pll_sel` and `pll_src` are low.
- R2: When `go` is seen high in a cycle after it was low, and `go_busy` is low, `go_busy` rises at the next clock edge. Keeping `go` high after that, or raising it while busy, starts no further change.
- R3: A divider word is written at address i (0 to NDIV-1). Bit 15 is the enable and bits RATIO_W-1:0 are the ratio. Such a write changes no output until a commit. After a commit, 0x8000 makes the divider tick every cycle with `div_on` high, and 0x0000 leaves `div_on` low and no ticks.
- R4: An enabled divider with ratio N ticks once every N+1 cycles.
- R5: The mask is written at address NDIV, and its bit i selects divider i. A commit happens at the first busy cycle in which every masked, enabled divider ticks. All staged words take effect at that edge and `go_busy` falls at the same edge. Each masked divider with ratio N then ticks on the cycles n where (n+1) mod (N+1) = 0, counting n = 0 as the first cycle after the commit.
- R6: Writes to divider words or to the mask while `go_busy` is high are ignored.
- R7: With a mask of zero, `go_busy` stays high for exactly one cycle.
- R8: `go_busy` is never high for more than ALIGN_TMO consecutive cycles. If no common boundary appears, the commit is forced in the ALIGN_TMO-th busy cycle, and the masked dividers restart in phase.
- R9: The mode word is written at address NDIV+1. Bit 0 is the PLL select and bit 5 the source select, and `pll_src` shows bit 5. `pll_sel` equals `pll_en_pin` when bit 5 is set, and equals bit 0 otherwise. Mode writes are accepted at any time.
- R10: A divider outside the mask is not restarted at a commit. It finishes its current count and uses its new ratio from its next reload on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Write address: dividers, then mask, then mode |
| cfg_wdata | input | 16 | Write data word |
| go | input | 1 | Start command bit; a low-to-high step starts a change |
| go_busy | output | 1 | High while a change is pending |
| pll_en_pin | input | 1 | External PLL enable, used when the source select is set |
| pll_sel | output | 1 | 0 = bypass, 1 = PLL |
| pll_src | output | 1 | Current source select |
| div_on | output | NDIV | Active enable of each divider |
| div_tick | output | NDIV | One-cycle tick of each divider |

## Verification
The bench builds the block with two dividers, 4-bit ratios and an ALIGN_TMO of 24. Periods of 3 and 5 cycles then share a boundary only every 15 cycles, so a realigned wait of twelve busy cycles can be measured exactly. A short timeout lets the bench hold two equal-period dividers out of phase and watch the forced commit end the wait after exactly 24 busy cycles. A masked-only change between periods 5 and 2 lets the bench check that an unmasked divider keeps its phase.

// File: rtl/divsync_pkg.sv
`timescale 1ns/1ps
package divsync_pkg;
  localparam int WORD_W       = 16;
  localparam int EN_BIT       = 15;
  localparam int MODE_PLL_BIT = 0;
  localparam int MODE_SRC_BIT = 5;

  typedef enum logic {
    GO_IDLE = 1'b0,
    GO_WAIT = 1'b1
  } go_state_e;
endpackage

// File: rtl/divsync_shadow.sv
`timescale 1ns/1ps
module divsync_shadow #(
  parameter int NDIV    = 2,
  parameter int RATIO_W = 6,
  parameter int ADDR_W  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [ADDR_W-1:0]              cfg_addr,
  input  logic [divsync_pkg::WORD_W-1:0] cfg_wdata,
  input  logic                           lock,
  output logic [NDIV-1:0]                sh_en,
  output logic [NDIV-1:0][RATIO_W-1:0]   sh_ratio,
  output logic [NDIV-1:0]                sh_mask,
  output logic                           mode_pll,
  output logic                           mode_src
);
  import divsync_pkg::*;

  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(NDIV);
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(NDIV + 1);

  logic open_wr;
  assign open_wr = cfg_we && !lock;

  // staged divider words, one slot per divider
  for (genvar i = 0; i < NDIV; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_en[i]    <= 1'b0;
        sh_ratio[i] <= '0;
      end else if (open_wr && cfg_addr == ADDR_W'(i)) begin
        sh_en[i]    <= cfg_wdata[EN_BIT];
        sh_ratio[i] <= cfg_wdata[RATIO_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_mask <= '0;
    end else if (open_wr && cfg_addr == MASK_ADDR) begin
      sh_mask <= cfg_wdata[NDIV-1:0];
    end
  end

  // mode word is not gated by the pending change
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_pll <= 1'b0;
      mode_src <= 1'b0;
    end else if (cfg_we && cfg_addr == MODE_ADDR) begin
      mode_pll <= cfg_wdata[MODE_PLL_BIT];
      mode_src <= cfg_wdata[MODE_SRC_BIT];
    end
  end
endmodule

// File: rtl/divsync_go.sv
`timescale 1ns/1ps
module divsync_go #(
  parameter int ALIGN_TMO = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic all_bound,
  output logic busy,
  output logic commit
);
  import divsync_pkg::*;

  localparam int TW = (ALIGN_TMO > 2) ? $clog2(ALIGN_TMO) : 1;
  localparam logic [TW-1:0] TMO_LAST = TW'(ALIGN_TMO - 1);

  go_state_e      state;
  logic           go_q;
  logic [TW-1:0]  wait_cnt;
  logic           start;

  assign start  = (state == GO_IDLE) && go && !go_q;
  assign busy   = (state == GO_WAIT);
  assign commit = busy && (all_bound || wait_cnt == TMO_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= GO_IDLE;
      go_q     <= 1'b0;
      wait_cnt <= '0;
    end else begin
      go_q <= go;
      if (start) begin
        state <= GO_WAIT;
      end else if (commit) begin
        state <= GO_IDLE;
      end
      if (!busy || commit) begin
        wait_cnt <= '0;
      end else begin
        wait_cnt <= wait_cnt + TW'(1);
      end
    end
  end
endmodule

// File: rtl/divsync_divider.sv
`timescale 1ns/1ps
module divsync_divider #(
  parameter int RATIO_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic               restart,
  input  logic               nxt_en,
  input  logic [RATIO_W-1:0] nxt_ratio,
  output logic               on,
  output logic               tick,
  output logic               at_bound
);
  logic               act_en;
  logic [RATIO_W-1:0] act_ratio;
  logic [RATIO_W-1:0] cnt;
  logic               rl_en;
  logic [RATIO_W-1:0] rl_ratio;

  // on a commit the reload uses the settings that take effect at that edge
  assign rl_en    = commit ? nxt_en : act_en;
  assign rl_ratio = commit ? nxt_ratio : act_ratio;

  assign on       = act_en;
  assign tick     = act_en && (cnt == '0);
  assign at_bound = !act_en || (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_en    <= 1'b0;
      act_ratio <= '0;
    end else if (commit) begin
      act_en    <= nxt_en;
      act_ratio <= nxt_ratio;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= nxt_en ? nxt_ratio : '0;
    end else if (tick) begin
      cnt <= rl_en ? rl_ratio : '0;
    end else if (!act_en) begin
      cnt <= '0;
    end else begin
      cnt <= cnt - RATIO_W'(1);
    end
  end
endmodule

// File: rtl/divsync_ctrl.sv
`timescale 1ns/1ps
module divsync_ctrl #(
  parameter int NDIV      = 2,
  parameter int RATIO_W   = 6,
  parameter int ALIGN_TMO = 1024,
  parameter int ADDR_W    = $clog2(NDIV + 2)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [ADDR_W-1:0]              cfg_addr,
  input  logic [divsync_pkg::WORD_W-1:0] cfg_wdata,
  input  logic                           go,
  output logic                           go_busy,
  input  logic                           pll_en_pin,
  output logic                           pll_sel,
  output logic                           pll_src,
  output logic [NDIV-1:0]                div_on,
  output logic [NDIV-1:0]                div_tick
);
  logic [NDIV-1:0]              sh_en;
  logic [NDIV-1:0][RATIO_W-1:0] sh_ratio;
  logic [NDIV-1:0]              sh_mask;
  logic [NDIV-1:0]              at_bound;
  logic                         mode_pll;
  logic                         all_bound;
  logic                         commit;

  divsync_shadow #(
    .NDIV    (NDIV),
    .RATIO_W (RATIO_W),
    .ADDR_W  (ADDR_W)
  ) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .lock      (go_busy),
    .sh_en     (sh_en),
    .sh_ratio  (sh_ratio),
    .sh_mask   (sh_mask),
    .mode_pll  (mode_pll),
    .mode_src  (pll_src)
  );

  // unmasked dividers never hold back the commit
  assign all_bound = &(at_bound | ~sh_mask);

  divsync_go #(
    .ALIGN_TMO (ALIGN_TMO)
  ) u_go (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .all_bound (all_bound),
    .busy      (go_busy),
    .commit    (commit)
  );

  for (genvar i = 0; i < NDIV; i++) begin : g_div
    divsync_divider #(
      .RATIO_W (RATIO_W)
    ) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit    (commit),
      .restart   (commit && sh_mask[i]),
      .nxt_en    (sh_en[i]),
      .nxt_ratio (sh_ratio[i]),
      .on        (div_on[i]),
      .tick      (div_tick[i]),
      .at_bound  (at_bound[i])
    );
  end

  assign pll_sel = pll_src ? pll_en_pin : mode_pll;
endmodule

// File: rtl/divsync_ctrl_chk.sv
`timescale 1ns/1ps
module divsync_ctrl_chk #(
  parameter int NDIV      = 2,
  parameter int ALIGN_TMO = 1024
) (
  input logic            clk,
  input logic            rst_n,
  input logic            go,
  input logic            go_busy,
  input logic [NDIV-1:0] div_on,
  input logic [NDIV-1:0] div_tick
);
  localparam int BW = $clog2(ALIGN_TMO + 2);
  localparam logic [BW-1:0] TMO_V = BW'(ALIGN_TMO);

  logic [BW-1:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_run <= '0;
    end else if (!go_busy) begin
      busy_run <= '0;
    end else if (busy_run < TMO_V) begin
      busy_run <= busy_run + BW'(1);
    end
  end

  // R1
  rst_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!go_busy && div_tick == '0 && div_on == '0));

  // R2
  go_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go_busy) |-> $past(go));

  // R3
  act_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_busy && $past(go_busy)) |-> $stable(div_on));

  // R8
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_busy |-> (busy_run < TMO_V));
endmodule

bind divsync_ctrl divsync_ctrl_chk #(
  .NDIV      (NDIV),
  .ALIGN_TMO (ALIGN_TMO)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .go       (go),
  .go_busy  (go_busy),
  .div_on   (div_on),
  .div_tick (div_tick)
);

// File: tb/divsync_ctrl_tb.sv
`timescale 1ns/1ps
module divsync_ctrl_tb;
  localparam int NDIV = 2;
  localparam int RW   = 4;
  localparam int TMO  = 24;
  localparam int AW   = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [AW-1:0]   cfg_addr = '0;
  logic [15:0]     cfg_wdata = '0;
  logic            go = 1'b0;
  logic            pll_en_pin = 1'b0;
  logic            go_busy, pll_sel, pll_src;
  logic [NDIV-1:0] div_on, div_tick;

  int   n_checks = 0;
  int   n_fail = 0;
  int   n = 0;
  logic prev_b = 1'b0;

  always #2 clk = ~clk;

  divsync_ctrl #(
    .NDIV      (NDIV),
    .RATIO_W   (RW),
    .ALIGN_TMO (TMO),
    .ADDR_W    (AW)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .go         (go),
    .go_busy    (go_busy),
    .pll_en_pin (pll_en_pin),
    .pll_sel    (pll_sel),
    .pll_src    (pll_src),
    .div_on     (div_on),
    .div_tick   (div_tick)
  );

  // cycles since the last commit, seen from the ports: n = 0 on the first sample after busy falls
  always @(negedge clk) begin
    if (!rst_n) n = 0;
    else if (prev_b && !go_busy) n = 0;
    else n = n + 1;
    prev_b = go_busy;
  end

  task automatic step();
    @(negedge clk);
    #0.5;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    cfg_we = 1'b1;
    cfg_addr = AW'(a);
    cfg_wdata = 16'(d);
    step();
    cfg_we = 1'b0;
  endtask

  task automatic go_wait(output int len);
    go = 1'b1;
    step();
    len = 0;
    while (go_busy && len < 200) begin
      go = 1'b0;
      len++;
      step();
    end
    go = 1'b0;
  endtask

  function automatic logic [1:0] model(input int nn, input bit e0, input int r0,
                                       input bit e1, input int r1);
    logic [1:0] m;
    m[0] = e0 && (((nn + 1) % (r0 + 1)) == 0);
    m[1] = e1 && (((nn + 1) % (r1 + 1)) == 0);
    return m;
  endfunction

  task automatic pattern(input int len, input bit e0, input int r0, input bit e1,
                         input int r1, input string tag);
    for (int k = 0; k < len; k++) begin
      logic [1:0] e;
      e = model(n, e0, r0, e1, r1);
      chk(div_tick == e, tag, int'(div_tick), int'(e));
      step();
    end
  endtask

  task automatic t_reset();
    chk(go_busy == 1'b0, "R1 busy after reset", int'(go_busy), 0);
    chk(div_tick == '0 && div_on == '0, "R1 dividers idle", int'({div_on, div_tick}), 0);
    chk(pll_sel == 1'b0 && pll_src == 1'b0, "R1 bypass mode", int'({pll_sel, pll_src}), 0);
  endtask

  task automatic t_staged();
    wr(0, 'h8000);
    wr(1, 'h0000);
    wr(2, 'h3);
    for (int k = 0; k < 3; k++) begin
      chk(div_tick == '0 && div_on == '0, "R3 staged word not applied",
          int'({div_on, div_tick}), 0);
      step();
    end
    go = 1'b1;
    step();
    chk(go_busy == 1'b1, "R2 busy follows go rise", int'(go_busy), 1);
    step();
    chk(go_busy == 1'b0, "R5 commit clears busy", int'(go_busy), 0);
    for (int k = 0; k < 4; k++) begin
      chk(go_busy == 1'b0, "R2 held go starts nothing", int'(go_busy), 0);
      step();
    end
    go = 1'b0;
    chk(div_on == 2'b01, "R3 enable bit applied", int'(div_on), 1);
    pattern(6, 1'b1, 0, 1'b0, 0, "R3 0x8000 ticks every cycle");
  endtask

  task automatic t_align_wait();
    int len;
    wr(0, 'h8002);
    wr(1, 'h8004);
    go_wait(len);
    chk(len == 1, "R5 immediate commit at boundary", len, 1);
    wr(0, 'h8001);
    wr(1, 'h8000);
    go = 1'b1;
    step();
    len = 0;
    while (go_busy && len < 100) begin
      logic [1:0] e;
      go = 1'b0;
      e = model(n, 1'b1, 2, 1'b1, 4);
      chk(div_tick == e, "R4 periods 3 and 5", int'(div_tick), int'(e));
      if (len == 0) begin
        cfg_we = 1'b1;
        cfg_addr = 2'd0;
        cfg_wdata = 16'h800F;
      end else begin
        cfg_we = 1'b0;
      end
      len++;
      step();
    end
    cfg_we = 1'b0;
    go = 1'b0;
    chk(len == 12, "R5 wait for common boundary", len, 12);
    pattern(12, 1'b1, 1, 1'b1, 0, "R6 busy write ignored, R5 restart in phase");
  endtask

  task automatic t_mask_zero();
    int len;
    wr(0, 'h8003);
    wr(1, 'h8001);
    wr(2, 'h0);
    go_wait(len);
    chk(len == 1, "R7 empty mask commits at once", len, 1);
  endtask

  task automatic t_unmasked_and_timeout();
    int len;
    wr(2, 'h3);
    wr(0, 'h8004);
    wr(1, 'h8001);
    go_wait(len);
    chk(len >= 1 && len <= TMO, "R8 busy bounded", len, TMO);
    wr(0, 'h8001);
    wr(2, 'h1);
    go_wait(len);
    chk(len == 2, "R5 masked divider boundary wait", len, 2);
    for (int k = 0; k < 8; k++) begin
      logic [1:0] e;
      e[0] = (n % 2) == 1;
      e[1] = (n % 2) == 0;
      chk(div_tick == e, "R10 unmasked divider keeps phase", int'(div_tick), int'(e));
      step();
    end
    wr(2, 'h3);
    go_wait(len);
    chk(len == TMO, "R8 forced commit after timeout", len, TMO);
    pattern(8, 1'b1, 1, 1'b1, 1, "R8 forced commit realigns");
  endtask

  task automatic t_mode();
    wr(3, 'h0001);
    chk(pll_sel == 1'b1 && pll_src == 1'b0, "R9 bit0 selects PLL", int'({pll_sel, pll_src}), 2);
    pll_en_pin = 1'b0;
    wr(3, 'h0020);
    chk(pll_sel == 1'b0 && pll_src == 1'b1, "R9 pin source low", int'({pll_sel, pll_src}), 1);
    pll_en_pin = 1'b1;
    step();
    chk(pll_sel == 1'b1, "R9 pin source high", int'(pll_sel), 1);
    wr(3, 'h0000);
    chk(pll_sel == 1'b0 && pll_src == 1'b0, "R9 back to bypass", int'({pll_sel, pll_src}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #0.5;
    rst_n = 1'b1;
    step();
    t_reset();
    t_staged();
    t_align_wait();
    t_mask_zero();
    t_unmasked_and_timeout();
    t_mode();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #600000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule